// File: doc/BRIEF.md
# Prescaled Watchdog Reset Timer

This block is a watchdog that counts pulses of a slow periodic tick and sends a one-clock reset pulse to the processor when software stops servicing it. The tick is a single-cycle enable in the system clock domain. It comes from an independent slow oscillator at a nominal one millisecond spacing. Software controls the watchdog by writing a small control word. That word holds an enable flag, a restart command and a 3-bit period code. The period code selects a timeout of 16, 32, 64 and so on, up to 2048 ticks.

The watchdog is off after power-on reset, and it counts nothing while the power-down input is high. A restart clears the tick count. The restart bit is a self-clearing command and never reads back as set. A new period code written while the watchdog runs does not shorten or stretch the interval already under way. The new period is taken up only at the next restart, or when the watchdog starts from the stopped state. When the timeout is reached, the reset output pulses for one clock and counting begins again from zero.

Top module: `wdg_timer`

## Requirements
- R1: After power-on reset (`por_n` low), the read-back word is zero and `cpu_rst_o` is low.
- R2: Code c selects a period of 16·2^c ticks (code 0 = 16, code 7 = 2048). Once the watchdog is running and not restarted, `cpu_rst_o` is high in the clock right after the edge that takes in the last tick of that period.
- R3: `cpu_rst_o` stays high for exactly one clock. The count then begins again from zero, so the next pulse needs another full period.
- R4: A write with bit 1 set (restart) clears the count. The next timeout needs a full period of ticks after that write.
- R5: The control word uses bit 0 for enable, bit 1 for restart and bits 4:2 for the period code. The read-back returns enable and code as written, and bit 1 always reads 0.
- R6: While `pwrdn_i` is high, no reset pulse occurs and the count is held at zero. After release, a full period is needed.
- R7: With enable at 0, no reset pulse occurs whatever the ticks do. Setting enable starts counting from zero.
- R8: A period code written while running, without restart, leaves the current period in force. This holds across timeouts, until the next restart or a start from the stopped state.
- R9: Only clocks with `tick_i` high advance the count. Idle clocks between ticks do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick_i | input | 1 | One-clock enable from the slow oscillator |
| pwrdn_i | input | 1 | Power-down state; holds the watchdog off |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 5 | Control word: bit 0 enable, bit 1 restart, bits 4:2 period code |
| ctl_rdata | output | 5 | Read-back of the control word, restart bit reads 0 |
| cpu_rst_o | output | 1 | One-clock reset pulse to the processor on timeout |

## Verification
The hardest case to reach is a period change deferred across a timeout. The bench first starts the watchdog with the shortest code and lets a few ticks pass. It then writes a longer code without a restart and confirms that the pulse still arrives after the short period. It lets a second short period expire as well, and only after a restart does it expect the longer interval. The power-down hold is reached the same way: power-down is raised in the middle of a period and many ticks are fed before it is released.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   // control word bit positions (software-visible layout)
   localparam int unsigned EN_BIT   = 0;
   localparam int unsigned KICK_BIT = 1;
   localparam int unsigned SEL_LSB  = 2;

   function automatic int unsigned ctl_width(input int unsigned sel_w);
      return sel_w + 2;
   endfunction

   // counter width wide enough for the largest period
   function automatic int unsigned cnt_width(input int unsigned base_log2,
                                             input int unsigned sel_w);
      return base_log2 + (1 << sel_w);
   endfunction
endpackage

// File: rtl/wdg_ctl_reg.sv
module wdg_ctl_reg #(
   parameter int unsigned SEL_W = 3,
   localparam int unsigned CW   = wdg_pkg::ctl_width(SEL_W)
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             we,
   input  logic [CW-1:0]    wdata,
   output logic             en_q,
   output logic [SEL_W-1:0] sel_q,
   output logic [SEL_W-1:0] sel_nxt,
   output logic             kick,
   output logic [CW-1:0]    rdata
);
   import wdg_pkg::*;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         en_q  <= 1'b0;
         sel_q <= '0;
      end else if (we) begin
         en_q  <= wdata[EN_BIT];
         sel_q <= wdata[SEL_LSB +: SEL_W];
      end
   end

   // the code that the period latch sees in this cycle
   assign sel_nxt = we ? wdata[SEL_LSB +: SEL_W] : sel_q;
   assign kick    = we & wdata[KICK_BIT];

   always_comb begin
      rdata                   = '0;
      rdata[EN_BIT]           = en_q;
      rdata[SEL_LSB +: SEL_W] = sel_q;
   end
endmodule

// File: rtl/wdg_limit.sv
module wdg_limit #(
   parameter int unsigned SEL_W     = 3,
   parameter int unsigned BASE_LOG2 = 4,
   parameter bit          USE_TABLE = 1'b1,
   localparam int unsigned CNT_W    = wdg_pkg::cnt_width(BASE_LOG2, SEL_W),
   localparam int unsigned NCODE    = 1 << SEL_W,
   localparam int unsigned SH_W     = $clog2(CNT_W) + 1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             load,
   input  logic [SEL_W-1:0] sel_nxt,
   output logic [CNT_W-1:0] lim_m1
);
   logic [SEL_W-1:0] act_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)    act_q <= '0;
      else if (load) act_q <= sel_nxt;
   end

   generate
      if (USE_TABLE) begin : g_table
         logic [CNT_W-1:0] tbl [NCODE];
         for (genvar g = 0; g < NCODE; g++) begin : g_ent
            assign tbl[g] = (CNT_W'(1) << (BASE_LOG2 + g)) - CNT_W'(1);
         end
         assign lim_m1 = tbl[act_q];
      end else begin : g_shift
         logic [SH_W-1:0] sh;
         assign sh     = SH_W'(BASE_LOG2) + SH_W'(act_q);
         assign lim_m1 = (CNT_W'(1) << sh) - CNT_W'(1);
      end
   endgenerate

   // R8: the active period moves only on a load
   a_r8_period_held: assert property (@(posedge clk) disable iff (!por_n)
      !load |=> $stable(lim_m1));
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             run,
   input  logic             kick,
   input  logic             tick,
   input  logic [CNT_W-1:0] lim_m1,
   output logic             cpu_rst
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q   <= '0;
         cpu_rst <= 1'b0;
      end else begin
         cpu_rst <= 1'b0;
         if (!run || kick) begin
            cnt_q <= '0;
         end else if (tick) begin
            if (cnt_q == lim_m1) begin
               cnt_q   <= '0;
               cpu_rst <= 1'b1;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   a_r3_single_clock: assert property (@(posedge clk) disable iff (!por_n)
      cpu_rst |=> !cpu_rst);
   a_r7_stopped_quiet: assert property (@(posedge clk) disable iff (!por_n)
      !run |=> !cpu_rst);
   a_r4_kick_clears: assert property (@(posedge clk) disable iff (!por_n)
      kick |=> (cnt_q == '0));
   a_r9_idle_holds: assert property (@(posedge clk) disable iff (!por_n)
      (run && !tick && !kick) |=> $stable(cnt_q));
   a_r2_within_period: assert property (@(posedge clk) disable iff (!por_n)
      cnt_q <= lim_m1);
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
   parameter int unsigned SEL_W     = 3,
   parameter int unsigned BASE_LOG2 = 4,
   parameter bit          USE_TABLE = 1'b1,
   localparam int unsigned CW       = wdg_pkg::ctl_width(SEL_W),
   localparam int unsigned CNT_W    = wdg_pkg::cnt_width(BASE_LOG2, SEL_W)
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          tick_i,
   input  logic          pwrdn_i,
   input  logic          ctl_we,
   input  logic [CW-1:0] ctl_wdata,
   output logic [CW-1:0] ctl_rdata,
   output logic          cpu_rst_o
);
   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("wdg_timer: SEL_W must be 1..4");
      end
      if (BASE_LOG2 < 1 || BASE_LOG2 > 16) begin : g_bad_base
         $error("wdg_timer: BASE_LOG2 must be 1..16");
      end
   endgenerate

   logic             en_q, kick, run, load;
   logic [SEL_W-1:0] sel_q, sel_nxt;
   logic [CNT_W-1:0] lim_m1;

   wdg_ctl_reg #(.SEL_W(SEL_W)) u_ctl (
      .clk(clk), .por_n(por_n), .we(ctl_we), .wdata(ctl_wdata),
      .en_q(en_q), .sel_q(sel_q), .sel_nxt(sel_nxt), .kick(kick),
      .rdata(ctl_rdata));

   assign run  = en_q & ~pwrdn_i;
   assign load = kick | ~run;

   wdg_limit #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .USE_TABLE(USE_TABLE)) u_lim (
      .clk(clk), .por_n(por_n), .load(load), .sel_nxt(sel_nxt),
      .lim_m1(lim_m1));

   wdg_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .por_n(por_n), .run(run), .kick(kick), .tick(tick_i),
      .lim_m1(lim_m1), .cpu_rst(cpu_rst_o));

   a_r6_powerdown_quiet: assert property (@(posedge clk) disable iff (!por_n)
      pwrdn_i |=> !cpu_rst_o);
   a_r5_kick_not_stored: assert property (@(posedge clk) disable iff (!por_n)
      ctl_we |=> (ctl_rdata[wdg_pkg::KICK_BIT] == 1'b0));
endmodule

// File: tb/sim_wdg_timer.sv
module sim_wdg_timer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       pwrdn_i = 1'b0;
   logic       ctl_we = 1'b0;
   logic [4:0] ctl_wdata = '0;
   logic [4:0] ctl_rdata;
   logic       cpu_rst_o;

   int checks = 0;
   int fails  = 0;
   int seen   = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdg_timer u0 (.clk(clk), .por_n(por_n), .tick_i(tick_i), .pwrdn_i(pwrdn_i),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .cpu_rst_o(cpu_rst_o));

   // rows: [2:0] period code, [4:3] idle clocks before each tick
   localparam logic [4:0] VEC [8] = '{
      {2'd0, 3'd0}, {2'd1, 3'd1}, {2'd0, 3'd2}, {2'd2, 3'd3},
      {2'd0, 3'd4}, {2'd0, 3'd5}, {2'd0, 3'd6}, {2'd0, 3'd7}};

   task automatic step();
      @(negedge clk);
      if (cpu_rst_o) seen++;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] w);
      ctl_we = 1'b1; ctl_wdata = w;
      step();
      ctl_we = 1'b0; ctl_wdata = '0;
   endtask

   task automatic ticks(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         repeat (gap) step();
         tick_i = 1'b1;
         step();
         tick_i = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      chk(ctl_rdata == 5'd0, "R1 readback", ctl_rdata, 0);
      chk(cpu_rst_o == 1'b0, "R1 cpu_rst", cpu_rst_o, 0);
      por_n = 1'b1;
      step();

      // R5: readback layout, restart bit reads zero
      wr(5'b11111);
      chk(ctl_rdata == 5'b11101, "R5 readback", ctl_rdata, 5'b11101);
      wr(5'b00000);

      // R2 / R3 / R9: table of codes and tick spacings
      for (int r = 0; r < 8; r++) begin
         int code, gap, per;
         code = int'(VEC[r][2:0]);
         gap  = int'(VEC[r][4:3]);
         per  = 16 << code;
         wr({VEC[r][2:0], 2'b11});
         seen = 0;
         ticks(per - 1, gap);
         chk(seen == 0, "R2 early pulse", seen, 0);
         ticks(1, gap);
         chk(cpu_rst_o == 1'b1, "R2 pulse at period", cpu_rst_o, 1);
         step();
         chk(cpu_rst_o == 1'b0, "R3 one clock", cpu_rst_o, 0);
         wr(5'b00000);
      end

      // R4: restart clears count
      wr(5'b00011);
      ticks(10, 0);
      wr(5'b00011);
      seen = 0;
      ticks(15, 0);
      chk(seen == 0, "R4 no pulse after restart", seen, 0);
      ticks(1, 0);
      chk(cpu_rst_o == 1'b1, "R4 pulse full period after restart", cpu_rst_o, 1);
      wr(5'b00000);

      // R8: deferred period change, R3 restart from zero
      wr(5'b00011);
      ticks(5, 0);
      wr(5'b01001);
      chk(ctl_rdata == 5'b01001, "R5 readback code2", ctl_rdata, 5'b01001);
      seen = 0;
      ticks(10, 0);
      chk(seen == 0, "R8 early", seen, 0);
      ticks(1, 0);
      chk(cpu_rst_o == 1'b1, "R8 old period kept", cpu_rst_o, 1);
      seen = 0;
      ticks(15, 0);
      chk(seen == 0, "R3 count restarted", seen, 0);
      ticks(1, 0);
      chk(cpu_rst_o == 1'b1, "R8 old period after timeout", cpu_rst_o, 1);
      wr(5'b01011);
      seen = 0;
      ticks(63, 0);
      chk(seen == 0, "R8 new period early", seen, 0);
      ticks(1, 0);
      chk(cpu_rst_o == 1'b1, "R8 new period after restart", cpu_rst_o, 1);
      wr(5'b00000);

      // R6: power-down holds off and clears
      wr(5'b00011);
      ticks(10, 0);
      pwrdn_i = 1'b1;
      seen = 0;
      ticks(40, 1);
      chk(seen == 0, "R6 no pulse in power-down", seen, 0);
      pwrdn_i = 1'b0;
      ticks(15, 0);
      chk(seen == 0, "R6 count cleared", seen, 0);
      ticks(1, 0);
      chk(cpu_rst_o == 1'b1, "R6 full period after release", cpu_rst_o, 1);

      // R7: disabled is quiet, enabling starts from zero
      wr(5'b00000);
      seen = 0;
      ticks(100, 0);
      chk(seen == 0, "R7 disabled quiet", seen, 0);
      wr(5'b00001);
      ticks(15, 0);
      chk(seen == 0, "R7 start early", seen, 0);
      ticks(1, 0);
      chk(cpu_rst_o == 1'b1, "R7 start from zero", cpu_rst_o, 1);

      // R9: idle clocks without tick do not count
      wr(5'b00011);
      seen = 0;
      ticks(15, 0);
      repeat (50) step();
      chk(seen == 0, "R9 idle no advance", seen, 0);
      ticks(1, 0);
      chk(cpu_rst_o == 1'b1, "R9 sixteenth tick", cpu_rst_o, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule